// File: doc/BRIEF.md
# Paged DMA Address and Count Generator

This block is the per-channel address and count engine of a DMA channel. A start command copies a 16-bit base address and a 16-bit base count into the working registers and records the channel kind. After that, every transfer acknowledge moves the working address up by one and the working count down by one. The 24-bit physical address is built from an 8-bit page register and the 16-bit working address. On a byte channel one page covers 64 KiB. On a word channel one page covers 128 KiB and the address counts 16-bit words. The page register is never stepped, so a run stays inside its page and the low address simply wraps.

The loaded count is the number of transfers minus one. When an acknowledge arrives while the count is zero, the count underflows to all ones and the block issues a one-cycle terminal-count pulse. It then either stops, or, when auto-init is set, reloads the working registers from the saved base values and keeps running. A residue output gives what remains: (count + 1) modulo 2^16, in bytes on byte channels and doubled on word channels.

Control is a two-state machine. IDLE is the reset state; the channel ignores acknowledges there. RUN is the state in which acknowledges step the channel. It has five transitions:
- ARM: IDLE to RUN on start.
- RESTART: RUN to RUN on start; it reloads from the new base values.
- STEP: RUN to RUN on an acknowledge with a nonzero count.
- RELOAD: RUN to RUN at terminal count with auto-init set.
- FINISH: RUN to IDLE at terminal count with auto-init clear.

Top module: `pgdma_addr_engine`

## Requirements
- R1: After reset the channel is idle (`active`=0), the working address is 0x0000, the working count is 0xFFFF, `phys_addr`=0, `tc_pulse`=0 and `residue`=0.
- R2: A `start` in either state saves `base_addr` and `base_cnt`, copies them into the working address and count, and latches `word_chan` (1 = word channel, 0 = byte channel). From the next cycle `active`=1.
- R3: On a byte channel, `phys_addr` = {page[7:0], working address[15:0]}.
- R4: On a word channel, `phys_addr` = {page[7:1], working address[15:0], 1'b0}. Page bit 0 and the address LSB never reach the output.
- R5: In RUN, an acknowledge with a nonzero count raises the working address by one and lowers the count by one, both modulo 2^16. The address wraps from 0xFFFF to 0x0000 with the page unchanged.
- R6: In RUN, an acknowledge with count 0x0000 makes `tc_pulse` high for exactly the next cycle. With `auto_init`=0 the address still steps, the count becomes 0xFFFF, and `active` falls.
- R7: At terminal count with `auto_init`=1, the working address and count are reloaded from the saved base values and `active` stays 1.
- R8: In IDLE, `xfer_ack` has no effect on the working address, the count or `tc_pulse`.
- R9: `page_we` loads `page_val` into the page register in either state and leaves the working address and count unchanged.
- R10: `residue` = (count + 1) mod 2^16 on a byte channel, and twice that on a word channel.
- R11: When `start` and `xfer_ack` arrive in the same cycle, `start` wins: the base values are loaded and no step happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_chan | input | 1 | Channel kind, latched on start: 1 = word, 0 = byte |
| page_we | input | 1 | Write strobe for the page register |
| page_val | input | 8 | New page value |
| base_addr | input | 16 | Base address, taken on start |
| base_cnt | input | 16 | Base count (transfers minus one), taken on start |
| auto_init | input | 1 | Reload from the base values at terminal count |
| start | input | 1 | Load the base values and arm the channel |
| xfer_ack | input | 1 | Transfer acknowledge strobe |
| phys_addr | output | 24 | Physical byte address |
| cur_cnt | output | 16 | Working count |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| residue | output | 17 | Remaining transfer length, in bytes |
| active | output | 1 | Channel in RUN |

## Verification
The stimulus drives the low address across 0xFFFF on both channel kinds. A design that carried into the page would show the wrong upper address bits. A word channel uses an odd page value, so a design that passes page bit 0 through, or leaks the address LSB, is caught. Terminal count is reached both with and without auto-init: a wrong design would miss the underflow to 0xFFFF, pulse for two cycles, keep running or fail to reload. Further cases cover acknowledges after FINISH, a page rewrite in the middle of a run, and start colliding with an acknowledge, which exposes a wrong priority.

// File: rtl/pgdma_pkg.sv
package pgdma_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pg_state_e;

    typedef enum logic [0:0] {
        CH_BYTE = 1'b0,
        CH_WORD = 1'b1
    } chan_kind_e;
endpackage

// File: rtl/pgdma_ctrl.sv
module pgdma_ctrl
    import pgdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic xfer_ack,
    input  logic auto_init,
    input  logic cnt_zero,
    output logic load_base,
    output logic reload,
    output logic step,
    output logic tc_pulse,
    output logic active
);
    pg_state_e state_q, state_d;
    logic      term;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and control strobes
    always_comb begin
        state_d   = state_q;
        load_base = 1'b0;
        reload    = 1'b0;
        step      = 1'b0;
        term      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin            // ARM
                    load_base = 1'b1;
                    state_d   = ST_RUN;
                end
            end
            ST_RUN: begin
                if (start) begin            // RESTART
                    load_base = 1'b1;
                end else if (xfer_ack) begin
                    if (cnt_zero) begin
                        term = 1'b1;
                        if (auto_init) begin
                            reload = 1'b1;  // RELOAD
                        end else begin
                            step    = 1'b1; // FINISH
                            state_d = ST_IDLE;
                        end
                    end else begin
                        step = 1'b1;        // STEP
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) tc_pulse <= 1'b0;
        else        tc_pulse <= term;
    end

    assign active = (state_q == ST_RUN);
endmodule

// File: rtl/pgdma_counters.sv
module pgdma_counters #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic              reload,
    input  logic              step,
    input  logic              word_chan,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_val,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] base_cnt,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] cur_cnt,
    output logic [PAGE_W-1:0] page_q,
    output logic              word_q,
    output logic              cnt_zero
);
    logic [ADDR_W-1:0] base_a_q, base_c_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_a_q <= '0;
            base_c_q <= '1;
            cur_addr <= '0;
            cur_cnt  <= '1;
            word_q   <= 1'b0;
        end else if (load_base) begin
            base_a_q <= base_addr;
            base_c_q <= base_cnt;
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
            word_q   <= word_chan;
        end else if (reload) begin
            cur_addr <= base_a_q;
            cur_cnt  <= base_c_q;
        end else if (step) begin
            cur_addr <= cur_addr + ADDR_W'(1);
            cur_cnt  <= cur_cnt - ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       page_q <= '0;
        else if (page_we) page_q <= page_val;
    end

    assign cnt_zero = (cur_cnt == '0);
endmodule

// File: rtl/pgdma_addr_map.sv
module pgdma_addr_map #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8,
    localparam int PHYS_W = ADDR_W + PAGE_W,
    localparam int RES_W  = ADDR_W + 1
) (
    input  logic              word_q,
    input  logic [PAGE_W-1:0] page_q,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] cur_cnt,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [RES_W-1:0]  residue
);
    logic [PHYS_W-1:0] byte_phys, word_phys;
    logic [ADDR_W-1:0] left;

    // the page sits above the address and is never carried into
    assign byte_phys = {page_q, cur_addr};
    generate
        if (PAGE_W > 1) begin : g_wide_page
            assign word_phys = {page_q[PAGE_W-1:1], cur_addr, 1'b0};
        end else begin : g_narrow_page
            assign word_phys = {cur_addr, 1'b0};
        end
    endgenerate

    assign phys_addr = word_q ? word_phys : byte_phys;

    assign left    = cur_cnt + ADDR_W'(1);
    assign residue = word_q ? {left, 1'b0} : {1'b0, left};
endmodule

// File: rtl/pgdma_addr_engine.sv
module pgdma_addr_engine #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8,
    localparam int PHYS_W = ADDR_W + PAGE_W,
    localparam int RES_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_chan,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_val,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] base_cnt,
    input  logic              auto_init,
    input  logic              start,
    input  logic              xfer_ack,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [ADDR_W-1:0] cur_cnt,
    output logic              tc_pulse,
    output logic [RES_W-1:0]  residue,
    output logic              active
);
    logic              load_base, reload, step, cnt_zero, word_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [PAGE_W-1:0] page_q;

    pgdma_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_ack(xfer_ack),
        .auto_init(auto_init), .cnt_zero(cnt_zero), .load_base(load_base),
        .reload(reload), .step(step), .tc_pulse(tc_pulse), .active(active)
    );

    pgdma_counters #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_base(load_base), .reload(reload),
        .step(step), .word_chan(word_chan), .page_we(page_we),
        .page_val(page_val), .base_addr(base_addr), .base_cnt(base_cnt),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt), .page_q(page_q),
        .word_q(word_q), .cnt_zero(cnt_zero)
    );

    pgdma_addr_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_map (
        .word_q(word_q), .page_q(page_q), .cur_addr(cur_addr),
        .cur_cnt(cur_cnt), .phys_addr(phys_addr), .residue(residue)
    );
endmodule

// File: rtl/pgdma_addr_engine_chk.sv
module pgdma_addr_engine_chk #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     xfer_ack,
    input logic                     auto_init,
    input logic                     word_q,
    input logic [ADDR_W+PAGE_W-1:0] phys_addr,
    input logic [ADDR_W-1:0]        cur_cnt,
    input logic                     tc_pulse,
    input logic [ADDR_W:0]          residue,
    input logic                     active
);
    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && xfer_ack && !start && cur_cnt != '0)
        |=> cur_cnt == ADDR_W'($past(cur_cnt) - ADDR_W'(1)));

    // R6
    tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);

    // R6
    tc_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && xfer_ack && !start && cur_cnt == '0 && !auto_init)
        |=> (tc_pulse && !active && cur_cnt == '1));

    // R7
    tc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && xfer_ack && !start && cur_cnt == '0 && auto_init)
        |=> (tc_pulse && active));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> ($stable(cur_cnt) && !tc_pulse));

    // R4
    word_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_q |-> (phys_addr[0] == 1'b0 && residue[0] == 1'b0));

    // R2
    start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> active);
endmodule

bind pgdma_addr_engine pgdma_addr_engine_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_ack(xfer_ack),
    .auto_init(auto_init), .word_q(word_q), .phys_addr(phys_addr),
    .cur_cnt(cur_cnt), .tc_pulse(tc_pulse), .residue(residue), .active(active)
);

// File: tb/pgdma_addr_engine_tb_top.sv
module pgdma_addr_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_chan = 1'b0, page_we = 1'b0, auto_init = 1'b0;
    logic        start = 1'b0, xfer_ack = 1'b0;
    logic [7:0]  page_val = '0;
    logic [15:0] base_addr = '0, base_cnt = '0;
    logic [23:0] phys_addr;
    logic [15:0] cur_cnt;
    logic        tc_pulse, active;
    logic [16:0] residue;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 1'b0;

    // reference model state
    int m_page, m_word, m_ba, m_bc, m_addr, m_cnt, m_act, m_tc;

    always #2 clk = ~clk;

    pgdma_addr_engine dut_i (
        .clk(clk), .rst_n(rst_n), .word_chan(word_chan), .page_we(page_we),
        .page_val(page_val), .base_addr(base_addr), .base_cnt(base_cnt),
        .auto_init(auto_init), .start(start), .xfer_ack(xfer_ack),
        .phys_addr(phys_addr), .cur_cnt(cur_cnt), .tc_pulse(tc_pulse),
        .residue(residue), .active(active)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int m_phys();
        if (m_word != 0) return ((m_page >> 1) << 17) | (m_addr << 1);
        return (m_page << 16) | m_addr;
    endfunction

    function automatic int m_res();
        int r = (m_cnt + 1) & 32'hFFFF;
        return (m_word != 0) ? r * 2 : r;
    endfunction

    // behavioural reference, updated from stable inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_page = 0; m_word = 0; m_ba = 0; m_bc = 32'hFFFF;
            m_addr = 0; m_cnt = 32'hFFFF; m_act = 0; m_tc = 0;
        end else begin
            m_tc = 0;
            if (page_we) m_page = page_val;
            if (start) begin
                m_ba = base_addr; m_bc = base_cnt;
                m_addr = base_addr; m_cnt = base_cnt;
                m_word = word_chan; m_act = 1;
            end else if (xfer_ack && m_act != 0) begin
                if (m_cnt == 0) begin
                    m_tc = 1;
                    if (auto_init) begin
                        m_addr = m_ba; m_cnt = m_bc;
                    end else begin
                        m_addr = (m_addr + 1) & 32'hFFFF;
                        m_cnt = 32'hFFFF; m_act = 0;
                    end
                end else begin
                    m_addr = (m_addr + 1) & 32'hFFFF;
                    m_cnt = m_cnt - 1;
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(m_word != 0 ? "R4 phys_addr" : "R3 phys_addr", int'(phys_addr), m_phys());
            check("R5 cur_cnt", int'(cur_cnt), m_cnt);
            check("R6 tc_pulse", int'(tc_pulse), m_tc);
            check("R2 active", int'(active), m_act);
            check("R10 residue", int'(residue), m_res());
        end
    end

    task automatic drive(input bit st, input bit xf, input bit pw, input logic [7:0] pv);
        @(negedge clk);
        start = st; xfer_ack = xf; page_we = pw; page_val = pv;
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<20000", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 active", int'(active), 0);
        check("R1 cur_cnt", int'(cur_cnt), 16'hFFFF);
        check("R1 phys_addr", int'(phys_addr), 0);
        check("R1 residue", int'(residue), 0);
        check("R1 tc_pulse", int'(tc_pulse), 0);

        // byte channel, address wraps inside page
        drive(0, 0, 1, 8'h12);
        base_addr = 16'hFFFE; base_cnt = 16'd3; word_chan = 1'b0; auto_init = 1'b0;
        drive(1, 0, 0, 8'h00);
        settle();
        check("R3 phys after start", int'(phys_addr), 24'h12FFFE);
        check("R2 active after start", int'(active), 1);
        drive(0, 1, 0, 0);
        drive(0, 1, 0, 0);
        settle();
        check("R5 wrap keeps page", int'(phys_addr), 24'h120000);
        drive(0, 0, 0, 0);
        drive(0, 1, 0, 0);
        drive(0, 1, 0, 0);
        settle();
        check("R6 tc high", int'(tc_pulse), 1);
        check("R6 count underflow", int'(cur_cnt), 16'hFFFF);
        check("R6 stopped", int'(active), 0);
        check("R10 residue zero", int'(residue), 0);
        drive(0, 1, 0, 0);
        settle();
        check("R6 tc one cycle", int'(tc_pulse), 0);
        check("R8 idle ignores ack", int'(phys_addr), 24'h120002);
        drive(0, 1, 0, 0);
        drive(0, 1, 0, 0);

        // word channel, odd page, auto-init
        base_addr = 16'hFFFF; base_cnt = 16'd2; word_chan = 1'b1; auto_init = 1'b1;
        drive(1, 0, 1, 8'h35);
        settle();
        check("R4 word map", int'(phys_addr), 24'h35FFFE);
        check("R10 word residue", int'(residue), 6);
        drive(0, 1, 0, 0);
        settle();
        check("R5 word wrap", int'(phys_addr), 24'h340000);
        drive(0, 1, 1, 8'h77);
        settle();
        check("R9 page rewrite", int'(phys_addr), 24'h760002);
        check("R9 count kept", int'(cur_cnt), 0);
        drive(0, 1, 0, 0);
        settle();
        check("R7 reload", int'(phys_addr), 24'h77FFFE);
        check("R7 still active", int'(active), 1);
        check("R7 tc", int'(tc_pulse), 1);
        drive(0, 1, 0, 0);
        drive(0, 0, 0, 0);

        // start and ack together
        base_addr = 16'h1234; base_cnt = 16'h0010; word_chan = 1'b0;
        drive(1, 1, 0, 0);
        settle();
        check("R11 start wins", int'(cur_cnt), 16'h0010);
        check("R11 start addr", int'(phys_addr), 24'h771234);
        repeat (20) drive(0, 1, 0, 0);
        auto_init = 1'b0;
        repeat (10) drive(0, 1, 0, 0);
        drive(0, 0, 0, 0);
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule